// File: doc/BRIEF.md
# Comparator Output Deglitch and Power-Path Latch-off

This block sits between an analog threshold comparator and the rest of the chip. It takes the comparator's raw decision (input above threshold), flips it according to a host-selected polarity, and drives a conditioned output pin level. Every move of the output towards LOW must survive a programmable filter window first. A move towards HIGH passes on the next clock. A host write port loads a five-bit control word: reference select, polarity, a two-bit filter code and a latch-off enable. A write that changes the word restarts the filter window.

When latch-off is enabled and one of the two long filter windows is selected, the edge that commits a LOW output also sets a sticky request to open both power-path switches. That request holds until power-on reset, or until the host writes the enable bit to zero. The reference-select bit is passed out as a level for the analog reference mux.

The filter windows are cycle counts given as parameters. The defaults are 1 µs, 2 ms and 5 s at 100 MHz.

Top module: `cmp_deglitch_latch`

## Requirements
- R1: After synchronous reset, `cmp_out` is 1, `ref_lo_sel` is 0 and `pwr_off_req` is 0. The control word resets to reference 0, polarity 0, filter code 2'b10 and latch-off enable 0.
- R2: The LOW condition is `cmp_above` when polarity (control bit 1) is 0. It is `!cmp_above` when polarity is 1.
- R3: Filter code (control bits 3:2) 01, 10 and 11 select DEG_1US, DEG_2MS and DEG_5S clock edges. `cmp_out` goes to 0 on the edge where the LOW condition has been sampled on that many consecutive edges. A shorter pulse leaves `cmp_out` at 1.
- R4: If the LOW condition is false at a clock edge that is not a restarting write, `cmp_out` is 1 after that edge.
- R5: With filter code 00, `cmp_out` stays 1 and no new latch-off can form.
- R6: A write (`ctl_wr`=1) whose data differs from the stored control word restarts the filter count from zero on that edge. A write of identical data does not disturb the count.
- R7: If latch-off enable (control bit 4) is 1 and the filter code is 10 or 11, the edge that commits `cmp_out` to 0 also sets `pwr_off_req`. The request then stays set.
- R8: With filter code 01, committing `cmp_out` to 0 leaves `pwr_off_req` at 0.
- R9: `pwr_off_req` clears on reset, and on the edge of any write whose bit 4 is 0.
- R10: `ref_lo_sel` equals bit 0 of the last written control word, from the edge of the write onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmp_above | input | 1 | Raw comparator decision, 1 when input is above threshold |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: [4] latch-off enable, [3:2] filter code, [1] polarity, [0] low reference select |
| cmp_out | output | 1 | Conditioned comparator output level |
| ref_lo_sel | output | 1 | Reference select level, 1 selects the lower reference |
| pwr_off_req | output | 1 | Latched request to open both power-path switches |

## Verification
All outputs are registered, so each result is due after a known number of clock edges.

- A rising output shows up one edge after the LOW condition drops.
- A falling output shows up exactly N edges after the condition first appears, where N is the selected count.
- `pwr_off_req` sets on that same edge.
- `ref_lo_sel` and a latch clear take effect on the write edge itself.

The bench drives and samples on falling clock edges. It counts edges from each stimulus and checks one edge before the due point as well as at it. This way a filter that runs one cycle early or late is caught. Filter windows are shrunk to 4, 10 and 20 edges.

// File: rtl/cmp_dg_pkg.sv
package cmp_dg_pkg;

  typedef enum logic [1:0] {
    DG_OFF  = 2'b00,
    DG_FAST = 2'b01,
    DG_MID  = 2'b10,
    DG_SLOW = 2'b11
  } dg_code_e;

  typedef struct packed {
    logic     latch_en;
    dg_code_e code;
    logic     pol;
    logic     ref_lo;
  } cmp_ctl_t;

  localparam cmp_ctl_t CTL_RESET = '{latch_en: 1'b0, code: DG_MID, pol: 1'b0, ref_lo: 1'b0};

endpackage

// File: rtl/cmp_ctl_reg.sv
module cmp_ctl_reg
  import cmp_dg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [4:0] wdata,
  output cmp_ctl_t   ctl,
  output logic       restart,
  output logic       latch_clr
);

  cmp_ctl_t wd;

  always_comb begin
    wd        = cmp_ctl_t'(wdata);
    restart   = wr && (wd != ctl);
    latch_clr = wr && !wd.latch_en;
  end

  always_ff @(posedge clk) begin
    if (rst)     ctl <= CTL_RESET;
    else if (wr) ctl <= wd;
  end

endmodule

// File: rtl/cmp_dg_timer.sv
module cmp_dg_timer
  import cmp_dg_pkg::*;
#(
  parameter int unsigned DEG_1US = 100,
  parameter int unsigned DEG_2MS = 200_000,
  parameter int unsigned DEG_5S  = 500_000_000
) (
  input  logic     clk,
  input  logic     rst,
  input  cmp_ctl_t ctl,
  input  logic     restart,
  input  logic     above,
  output logic     out_lvl,
  output logic     fire
);

  localparam int unsigned CNT_W = $clog2(DEG_5S + 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(DEG_1US - 1);
  localparam logic [CNT_W-1:0] LAST_MID  = CNT_W'(DEG_2MS - 1);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(DEG_5S - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             low_cond;
  logic             at_end;

  always_comb begin
    unique case (ctl.code)
      DG_FAST: last = LAST_FAST;
      DG_MID:  last = LAST_MID;
      DG_SLOW: last = LAST_SLOW;
      default: last = '0;
    endcase
    low_cond = (ctl.code != DG_OFF) && (ctl.pol ? !above : above);
    at_end   = (cnt == last);
    fire     = !restart && low_cond && out_lvl && at_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      out_lvl <= 1'b1;
    end else if (restart) begin
      cnt <= '0;
    end else if (!low_cond) begin
      cnt     <= '0;
      out_lvl <= 1'b1;
    end else if (out_lvl) begin
      if (at_end) begin
        cnt     <= '0;
        out_lvl <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

endmodule

// File: rtl/cmp_latchoff.sv
module cmp_latchoff
  import cmp_dg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  cmp_ctl_t ctl,
  input  logic     fire,
  input  logic     clr,
  output logic     req
);

  logic long_code;

  always_comb long_code = (ctl.code == DG_MID) || (ctl.code == DG_SLOW);

  always_ff @(posedge clk) begin
    if (rst || clr)                             req <= 1'b0;
    else if (fire && ctl.latch_en && long_code) req <= 1'b1;
  end

endmodule

// File: rtl/cmp_deglitch_latch.sv
module cmp_deglitch_latch
  import cmp_dg_pkg::*;
#(
  parameter int unsigned DEG_1US = 100,
  parameter int unsigned DEG_2MS = 200_000,
  parameter int unsigned DEG_5S  = 500_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmp_above,
  input  logic       ctl_wr,
  input  logic [4:0] ctl_wdata,
  output logic       cmp_out,
  output logic       ref_lo_sel,
  output logic       pwr_off_req
);

  cmp_ctl_t ctl_q;
  logic     restart;
  logic     latch_clr;
  logic     fire;

  cmp_ctl_reg i_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctl_wr),
    .wdata     (ctl_wdata),
    .ctl       (ctl_q),
    .restart   (restart),
    .latch_clr (latch_clr)
  );

  cmp_dg_timer #(
    .DEG_1US (DEG_1US),
    .DEG_2MS (DEG_2MS),
    .DEG_5S  (DEG_5S)
  ) i_tmr (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl_q),
    .restart (restart),
    .above   (cmp_above),
    .out_lvl (cmp_out),
    .fire    (fire)
  );

  cmp_latchoff i_lat (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl_q),
    .fire (fire),
    .clr  (latch_clr),
    .req  (pwr_off_req)
  );

  always_comb ref_lo_sel = ctl_q.ref_lo;

endmodule

// File: rtl/cmp_deglitch_latch_chk.sv
module cmp_deglitch_latch_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmp_above,
  input logic       ctl_wr,
  input logic [4:0] ctl_wdata,
  input logic [4:0] ctl_q,
  input logic       cmp_out,
  input logic       ref_lo_sel,
  input logic       pwr_off_req
);

  logic chg_wr;
  logic low_c;

  always_comb begin
    chg_wr = ctl_wr && (ctl_wdata != ctl_q);
    low_c  = (ctl_q[3:2] != 2'b00) && (ctl_q[1] ? !cmp_above : cmp_above);
  end

  AST_RISE_PROMPT: assert property (@(posedge clk) disable iff (rst)
    (!low_c && !chg_wr) |=> cmp_out); // R4

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    ((ctl_q[3:2] == 2'b00) && !chg_wr) |=> cmp_out); // R5

  AST_FALL_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
    (cmp_out && !chg_wr && !low_c) |=> cmp_out); // R3

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pwr_off_req && !(ctl_wr && !ctl_wdata[4])) |=> pwr_off_req); // R7

  AST_LATCH_NEEDS_LONG_CODE: assert property (@(posedge clk) disable iff (rst)
    (!pwr_off_req && !(ctl_q[4] && ctl_q[3])) |=> !pwr_off_req); // R8

  AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_wdata[4]) |=> !pwr_off_req); // R9

  AST_REF_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (ref_lo_sel == $past(ctl_wdata[0]))); // R10

endmodule

bind cmp_deglitch_latch cmp_deglitch_latch_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .cmp_above   (cmp_above),
  .ctl_wr      (ctl_wr),
  .ctl_wdata   (ctl_wdata),
  .ctl_q       (ctl_q),
  .cmp_out     (cmp_out),
  .ref_lo_sel  (ref_lo_sel),
  .pwr_off_req (pwr_off_req)
);

// File: tb/test_cmp_deglitch_latch.sv
module test_cmp_deglitch_latch;

  localparam int T1 = 4;
  localparam int T2 = 10;
  localparam int T3 = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_above = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = 5'b0;
  logic       cmp_out;
  logic       ref_lo_sel;
  logic       pwr_off_req;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  cmp_deglitch_latch #(.DEG_1US(T1), .DEG_2MS(T2), .DEG_5S(T3)) i_cmp_deglitch_latch (
    .clk         (clk),
    .rst         (rst),
    .cmp_above   (cmp_above),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .cmp_out     (cmp_out),
    .ref_lo_sel  (ref_lo_sel),
    .pwr_off_req (pwr_off_req)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [4:0] d);
    ctl_wdata = d;
    ctl_wr    = 1'b1;
    @(negedge clk);
    ctl_wr    = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "cmp_out", cmp_out, 1'b1);
    chk("R1", "ref_lo_sel", ref_lo_sel, 1'b0);
    chk("R1", "pwr_off_req", pwr_off_req, 1'b0);
    cmp_above = 1'b1;                 // default code 10 must filter T2 edges
    wait_n(T2 - 1);
    chk("R1", "cmp_out before default window", cmp_out, 1'b1);
    wait_n(1);
    chk("R1", "cmp_out after default window", cmp_out, 1'b0);
    cmp_above = 1'b0;
    wait_n(1);
  endtask

  task automatic t_glitch_mid;
    write_ctl(5'b01000);
    wait_n(2);
    cmp_above = 1'b1;
    wait_n(T2 - 1);
    chk("R3", "short pulse", cmp_out, 1'b1);
    cmp_above = 1'b0;
    wait_n(1);
    chk("R3", "after short pulse", cmp_out, 1'b1);
    cmp_above = 1'b1;
    wait_n(T2 - 1);
    chk("R3", "one edge early", cmp_out, 1'b1);
    wait_n(1);
    chk("R3", "full window", cmp_out, 0);
    cmp_above = 1'b0;
    wait_n(1);
    chk("R4", "prompt rise", cmp_out, 1'b1);
  endtask

  task automatic t_polarity_fast;
    cmp_above = 1'b1;
    write_ctl(5'b00110);
    wait_n(2);
    chk("R2", "pol1 above gives high", cmp_out, 1'b1);
    cmp_above = 1'b0;
    wait_n(T1 - 1);
    chk("R3", "fast window early", cmp_out, 1'b1);
    wait_n(1);
    chk("R2", "pol1 below gives low", cmp_out, 1'b0);
    cmp_above = 1'b1;
    wait_n(1);
    chk("R4", "pol1 prompt rise", cmp_out, 1'b1);
    cmp_above = 1'b0;
    write_ctl(5'b01000);
    wait_n(2);
  endtask

  task automatic t_rewrite;
    cmp_above = 1'b1;
    wait_n(5);
    write_ctl(5'b01001);
    chk("R10", "ref_lo_sel after write", ref_lo_sel, 1'b1);
    wait_n(T2 - 1);
    chk("R6", "restarted window", cmp_out, 1'b1);
    wait_n(1);
    chk("R6", "low after restarted window", cmp_out, 1'b0);
    cmp_above = 1'b0;
    wait_n(1);
    cmp_above = 1'b1;
    wait_n(5);
    write_ctl(5'b01001);
    wait_n(T2 - 7);
    chk("R6", "same data write keeps count", cmp_out, 1'b1);
    wait_n(1);
    chk("R6", "same data write low on time", cmp_out, 1'b0);
    cmp_above = 1'b0;
    write_ctl(5'b01000);
    chk("R10", "ref_lo_sel cleared", ref_lo_sel, 1'b0);
    wait_n(1);
  endtask

  task automatic t_latch_mid;
    write_ctl(5'b11000);
    wait_n(2);
    cmp_above = 1'b1;
    wait_n(T2 - 1);
    chk("R7", "no request before trigger", pwr_off_req, 1'b0);
    wait_n(1);
    chk("R7", "request on trigger edge", pwr_off_req, 1'b1);
    cmp_above = 1'b0;
    wait_n(3);
    chk("R4", "output recovers", cmp_out, 1'b1);
    chk("R7", "request held", pwr_off_req, 1'b1);
    write_ctl(5'b01000);
    chk("R9", "cleared by enable write 0", pwr_off_req, 1'b0);
  endtask

  task automatic t_no_latch_fast;
    write_ctl(5'b10100);
    wait_n(2);
    cmp_above = 1'b1;
    wait_n(T1);
    chk("R8", "fast code output low", cmp_out, 1'b0);
    chk("R8", "fast code no request", pwr_off_req, 1'b0);
    wait_n(5);
    chk("R8", "fast code still no request", pwr_off_req, 1'b0);
    cmp_above = 1'b0;
    wait_n(1);
  endtask

  task automatic t_disabled;
    write_ctl(5'b10000);
    cmp_above = 1'b1;
    wait_n(T3 + 5);
    chk("R5", "disabled output", cmp_out, 1'b1);
    chk("R5", "disabled no request", pwr_off_req, 1'b0);
    cmp_above = 1'b0;
    wait_n(1);
  endtask

  task automatic t_slow_reset;
    write_ctl(5'b11100);
    wait_n(2);
    cmp_above = 1'b1;
    wait_n(T3 - 1);
    chk("R3", "slow window early", cmp_out, 1'b1);
    wait_n(1);
    chk("R3", "slow window low", cmp_out, 1'b0);
    chk("R7", "slow code request", pwr_off_req, 1'b1);
    rst = 1'b1;
    wait_n(1);
    rst = 1'b0;
    chk("R9", "reset clears request", pwr_off_req, 1'b0);
    chk("R1", "reset output high", cmp_out, 1'b1);
    cmp_above = 1'b0;
    wait_n(1);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_glitch_mid();
    t_polarity_fast();
    t_rewrite();
    t_latch_mid();
    t_no_latch_fast();
    t_disabled();
    t_slow_reset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule